// File: doc/BRIEF.md
# Push-pull gate steering with blanking and dead time

This block sits between an oscillator and the two gate drivers of a push-pull or bridge converter. Each oscillator strobe hands the next on-time to the output that did not switch last, so the two outputs alternate. Each output therefore runs at half the oscillator rate, and neither one exceeds half of the total time. Before an output turns on, a programmable gap of dark clock cycles keeps both switches off. An on-time ends at the next oscillator strobe (duty limit), at a current-limit trip, or at a PWM-compare trip. The PWM-compare trip is masked for the first cycles of every on-time. The current-limit trip is never masked. All timing is counted in cycles of the fast system clock.

The controller is a five-state machine. IDLE: disabled, or waiting for the first strobe. GAP: dead-time counting, both outputs low. BLANK: output on, PWM trip masked. ON: output on, both trips active. OFF: the on-time has been cut short and the block waits for the strobe. The transitions are:
- IDLE to GAP or BLANK on a strobe.
- GAP to BLANK when the gap count completes.
- BLANK to ON when the mask window completes.
- BLANK to OFF on a current-limit trip.
- ON to OFF on either trip.
- BLANK, ON or OFF back to GAP or BLANK on a strobe, with the side flipped. GAP is skipped when the dead count is zero.
- Any state to IDLE while the enable is low.

Top module: `ppw_steer`

## Requirements
- R1: After reset, both gate outputs are low. They stay low with enable high until the first oscillator strobe.
- R2: While `en` is low, both outputs are low in the same cycle, and strobes have no effect.
- R3: The first on-time after enable rises always goes to `gate_a`. Dropping `en` resets the side selection.
- R4: Each strobe passes the on-time to the other output. `gate_a` stays low during the period that belongs to `gate_b`.
- R5: When a strobe is sampled at edge E, the next output is low for exactly `dead_cyc` cycles after E and rises after edge E+`dead_cyc`. A `dead_cyc` of 0 switches sides in one edge, giving a combined 100% duty.
- R6: With no trip, an output stays high until the next strobe edge. Its high time is the strobe period minus `dead_cyc` cycles.
- R7: The PWM trip is ignored during on-cycles 0 to MASK-1, where MASK = max(BLANK_CYC, MIN_ON_CYC) (6 by default). A PWM trip sampled in on-cycle i ≥ MASK gives an on-time of i+1 cycles.
- R8: A current-limit trip sampled in any on-cycle i, inside the mask window or not, gives an on-time of i+1 cycles.
- R9: A terminated output stays low until the next strobe.
- R10: `gate_a` and `gate_b` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en | input | 1 | enable; low forces both outputs low |
| osc_tick | input | 1 | one-cycle oscillator strobe |
| pwm_trip | input | 1 | PWM-compare terminate flag |
| ilim_trip | input | 1 | current-limit terminate flag |
| dead_cyc | input | DT_W | dead-time gap in clock cycles |
| gate_a | output | 1 | gate enable, side A |
| gate_b | output | 1 | gate enable, side B |

## Verification
The bench runs the main function over several input patterns:
- Two full strobe periods with no trip, at dead counts of 0 to 5. This separates the duty limit, the gap length and the side alternation.
- PWM trips placed just before, on, and well past the end of the mask window. This locates the mask boundary to the exact cycle.
- Current-limit trips inside the mask window and alongside a later PWM trip. This shows that the current limit is never masked and that the earlier trip wins.

Directed tests then drop the enable in the middle of an on-time and strobe while disabled. They also re-enable after side B has been active, to show that the side selection restarts at A.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_BLANK,
        ST_ON,
        ST_OFF
    } ppw_state_e;
endpackage

// File: rtl/ppw_cycle_ctr.sv
module ppw_cycle_ctr #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;

    // Saturating up-counter; clear has priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!(&cnt_q)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ppw_trip_merge.sv
module ppw_trip_merge (
    input  logic blanked,
    input  logic pwm_trip,
    input  logic ilim_trip,
    output logic stop_now
);
    // The current limit always passes; the PWM trip only outside the mask.
    always_comb begin
        stop_now = ilim_trip | (pwm_trip & ~blanked);
    end
endmodule

// File: rtl/ppw_steer.sv
module ppw_steer #(
    parameter int BLANK_CYC  = 4,
    parameter int MIN_ON_CYC = 6,
    parameter int DT_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            osc_tick,
    input  logic            pwm_trip,
    input  logic            ilim_trip,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            gate_a,
    output logic            gate_b
);
    import ppw_pkg::*;

    localparam int MASK_CYC = (BLANK_CYC > MIN_ON_CYC) ? BLANK_CYC : MIN_ON_CYC;
    localparam int MASK_W   = $clog2(MASK_CYC + 1);
    localparam int CW       = ((MASK_W > DT_W) ? MASK_W : DT_W) + 1;

    ppw_state_e    state_q, state_d;
    logic          side_q, side_d;   // 0 = side A, 1 = side B
    logic          cnt_clr;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_p1;
    logic          gap_done, mask_done, dead_zero;
    logic          in_blank, stop_now, on_now;
    ppw_state_e    launch_st;

    ppw_cycle_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    ppw_trip_merge u_trip (
        .blanked   (in_blank),
        .pwm_trip  (pwm_trip),
        .ilim_trip (ilim_trip),
        .stop_now  (stop_now)
    );

    always_comb begin
        cnt_p1    = cnt + CW'(1);
        gap_done  = (cnt_p1 == CW'(dead_cyc));
        mask_done = (cnt_p1 == CW'(MASK_CYC));
        dead_zero = (dead_cyc == '0);
        in_blank  = (state_q == ST_BLANK);
        launch_st = dead_zero ? ST_BLANK : ST_GAP;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        side_d  = side_q;
        cnt_clr = 1'b0;
        if (!en) begin
            state_d = ST_IDLE;
            side_d  = 1'b0;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (osc_tick) begin
                        state_d = launch_st;
                        side_d  = 1'b0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        state_d = ST_BLANK;
                        cnt_clr = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (osc_tick) begin
                        state_d = launch_st;
                        side_d  = ~side_q;
                        cnt_clr = 1'b1;
                    end else if (stop_now) begin
                        state_d = ST_OFF;
                    end else if (mask_done) begin
                        state_d = ST_ON;
                    end
                end
                ST_ON: begin
                    if (osc_tick) begin
                        state_d = launch_st;
                        side_d  = ~side_q;
                        cnt_clr = 1'b1;
                    end else if (stop_now) begin
                        state_d = ST_OFF;
                    end
                end
                ST_OFF: begin
                    if (osc_tick) begin
                        state_d = launch_st;
                        side_d  = ~side_q;
                        cnt_clr = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    side_d  = 1'b0;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            side_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            side_q  <= side_d;
        end
    end

    // Outputs
    always_comb begin
        on_now = (state_q == ST_BLANK) || (state_q == ST_ON);
        gate_a = en & on_now & ~side_q;
        gate_b = en & on_now & side_q;
    end

    a_r10_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a && gate_b));

    a_r2_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE && !side_q));

    a_r3_first_side_a: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_IDLE && osc_tick) |=> !side_q);

    a_r4_side_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (en && osc_tick && state_q inside {ST_BLANK, ST_ON, ST_OFF})
        |=> (side_q != $past(side_q)));

    a_r5_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (!gate_a && !gate_b));

    a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_BLANK && !ilim_trip && !osc_tick)
        |=> (state_q inside {ST_BLANK, ST_ON}));

    a_r8_ilim_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (gate_a || gate_b) && ilim_trip && !osc_tick)
        |=> (!gate_a && !gate_b));

    a_r9_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_OFF && !osc_tick) |=> (!gate_a && !gate_b));
endmodule

// File: tb/ppw_steer_tb_top.sv
module ppw_steer_tb_top;
    localparam int P    = 32;
    localparam int NONE = 99;
    localparam int NV   = 9;
    // dead, pwm on-cycle, ilim on-cycle, expected A on-length
    localparam int VEC [NV][4] = '{
        '{2, NONE, NONE, 30},   // R6 duty limit
        '{0, NONE, NONE, 32},   // R5 zero gap, 100 %
        '{3, 10,   NONE, 11},   // R7 pwm after mask
        '{3, 2,    NONE, 29},   // R7 pwm in mask ignored
        '{1, 5,    NONE, 31},   // R7 last masked cycle
        '{1, 6,    NONE, 7},    // R7 first unmasked cycle
        '{2, NONE, 1,    2},    // R8 ilim inside mask
        '{2, 20,   15,   16},   // R8 ilim before pwm
        '{5, NONE, 0,    1}     // R8 ilim at first cycle
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       pwm = 1'b0;
    logic       ilim = 1'b0;
    logic [3:0] dead = '0;
    logic       ga, gb;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    ppw_steer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .osc_tick  (tick),
        .pwm_trip  (pwm),
        .ilim_trip (ilim),
        .dead_cyc  (dead),
        .gate_a    (ga),
        .gate_b    (gb)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(int d, int pi, int li, int exp_len);
        int a_len = 0, b_len = 0, a_gap = -1, ov = 0, a2 = 0;
        @(negedge clk);
        en = 1'b0; tick = 1'b0; pwm = 1'b0; ilim = 1'b0; dead = 4'(d);
        @(negedge clk);
        en = 1'b1; tick = 1'b1;
        for (int t = 0; t < 2 * P; t++) begin
            @(negedge clk);
            if (ga && gb) ov++;
            if (t < P) begin
                if (ga) begin
                    a_len++;
                    if (a_gap < 0) a_gap = t;
                end
            end else begin
                if (ga) a2++;
                if (gb) b_len++;
            end
            tick = (t + 1 == P);
            pwm  = (t < P) && (t == d + pi);
            ilim = (t < P) && (t == d + li);
        end
        tick = 1'b0; pwm = 1'b0; ilim = 1'b0;
        chk("R5 gap before A", a_gap, d);
        chk("R6/R7/R8/R9 A on-length", a_len, exp_len);
        chk("R4/R5 B on-length", b_len, P - d);
        chk("R4 A quiet in B period", a2, 0);
        chk("R10 overlap", ov, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then enabled but no strobe yet
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 gate_a in reset", int'(ga), 0);
        chk("R1 gate_b in reset", int'(gb), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 gate_a before strobe", int'(ga), 0);
        chk("R1 gate_b before strobe", int'(gb), 0);

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
        end

        // R2: enable drop cuts an active output in the same cycle
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1; dead = 4'd0; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        chk("R3 A on after enable", int'(ga), 1);
        en = 1'b0;
        #1;
        chk("R2 gate_a drops with en", int'(ga), 0);
        chk("R2 gate_b with en low", int'(gb), 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R2 strobe ignored A", int'(ga), 0);
        chk("R2 strobe ignored B", int'(gb), 0);

        // R3: B active, disable, re-enable restarts at A
        @(negedge clk); en = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R4 B after second strobe", int'(gb), 1);
        en = 1'b0;
        @(negedge clk); en = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R3 restart on A", int'(ga), 1);
        chk("R3 restart not B", int'(gb), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule